// File: doc/BRIEF.md
# Floating-Point Exception Status and Control Register

This block is the status and control register that sits beside a floating-point arithmetic unit. It keeps four fields:

- **Cause field.** Records the exceptions raised by the most recent operation. It is wiped at the start of every operation.
- **Trap-enable field.** Marks which maskable exceptions should interrupt the processor.
- **Sticky flag field.** Accumulates every maskable exception seen since software last cleared it.
- **Rounding-mode field.** A two-bit field read by the arithmetic unit.

The datapath signals the start of an operation with a one-cycle pulse. It reports the exceptions of that operation with a completion pulse that carries a six-bit exception vector. The processor reads and writes the whole register through a 32-bit port. The block drives two outputs:

- **Rounding mode.** Reserved codes are folded back to round-to-nearest.
- **Trap request.** Raised when a recorded cause is enabled, or when the unmaskable error cause is set.

Top module: `fpx_status_reg`

## Requirements
- R1: After reset the read value is 0, the trap request is low and the rounding-mode output is 00.
- R2: An operation-start pulse without a completion in the same cycle clears all six cause bits (17:12) and leaves the flag bits (6:2) unchanged.
- R3: A completion pulse sets the cause bits and flag bits that match the exception vector. The vector has bit 5 = error (E), 4 = invalid (V), 3 = divide-by-zero (Z), 2 = overflow (O), 1 = underflow (U) and 0 = inexact (I). Cause positions are E 17, V 16, Z 15, O 14, U 13, I 12. Flag positions are V 6, Z 5, O 4, U 3, I 2. E sets no flag bit.
- R4: Flag bits are sticky: later operations never clear them; only a CPU write changes them to a lower value.
- R5: When the start and completion pulses arrive in the same cycle, the cause field afterwards holds exactly that operation's exceptions.
- R6: A set E cause bit raises the trap request whatever the enable field holds.
- R7: The trap request is raised when a V, Z, O, U or I cause bit is set and its enable bit is set. The enable positions are V 11, Z 10, O 9, U 8, I 7. A cause bit whose enable is clear raises no trap.
- R8: A CPU write loads bits 17:0 into the register, and the read port returns them from the next cycle.
- R9: Bits 31:18 always read as 0, whatever is written to them.
- R10: When a CPU write and a completion pulse or start pulse coincide, the register takes the written value and the operation update is dropped.
- R11: The rounding-mode output is 01 when bits 1:0 hold 01, and 00 for 00, 10 and 11. The read port returns the raw bits 1:0 as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Pulse at the start of an arithmetic operation |
| op_done | input | 1 | Pulse when an operation completes |
| op_exc | input | 6 | Exceptions of the completing operation: {E,V,Z,O,U,I} |
| cpu_wr_en | input | 1 | CPU write strobe |
| cpu_wr_data | input | 32 | CPU write data |
| cpu_rd_data | output | 32 | Current register value |
| rnd_mode | output | 2 | Effective rounding mode: 00 nearest, 01 toward zero |
| trap_req | output | 1 | Exception trap request |

## Verification
The assertions assume three things about the inputs:

- `op_exc` is meaningful only while `op_done` is high.
- Reset is held for at least one clock edge before any pulse arrives.
- A CPU write in the same cycle as an operation update is allowed and has a defined winner.

The directed stimulus changes inputs only on falling clock edges and raises each pulse for exactly one cycle. It deliberately overlaps start with completion, and a write with a completion, so that the priority properties are exercised as well as the single-event paths.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    localparam int REG_W     = 32;
    localparam int EXC_N     = 5;
    localparam int CAUSE_W   = EXC_N + 1;
    localparam int RM_W      = 2;
    localparam int RM_LSB    = 0;
    localparam int FLAG_LSB  = RM_LSB + RM_W;
    localparam int EN_LSB    = FLAG_LSB + EXC_N;
    localparam int CAUSE_LSB = EN_LSB + EXC_N;
    localparam int USED_W    = CAUSE_LSB + CAUSE_W;

    typedef logic [EXC_N-1:0] exc_mask_t;

    typedef struct packed {
        logic      err;
        exc_mask_t mask;
    } exc_vec_t;

    typedef enum logic [RM_W-1:0] {
        RND_NEAREST = 2'b00,
        RND_ZERO    = 2'b01
    } rnd_t;

    typedef struct packed {
        exc_vec_t        cause;
        exc_mask_t       enable;
        exc_mask_t       flags;
        logic [RM_W-1:0] rm;
    } csr_fields_t;

    function automatic rnd_t rnd_decode(logic [RM_W-1:0] raw);
        return (raw == RND_ZERO) ? RND_ZERO : RND_NEAREST;
    endfunction

    function automatic logic [REG_W-1:0] pack_csr(csr_fields_t f);
        return {{(REG_W-USED_W){1'b0}}, f};
    endfunction

endpackage

// File: rtl/fpx_cause_reg.sv
module fpx_cause_reg
    import fpx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     op_start,
    input  logic     op_done,
    input  exc_vec_t op_exc,
    input  logic     wr_en,
    input  exc_vec_t wr_val,
    output exc_vec_t q
);

    exc_vec_t base;
    exc_vec_t add;

    always_comb begin
        base = op_start ? exc_vec_t'('0) : q;
        add  = op_done  ? op_exc        : exc_vec_t'('0);
    end

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wr_val;
        else            q <= base | add;
    end

    assert_cause_clear_R2: assert property (@(posedge clk) disable iff (rst)
        (op_start && !op_done && !wr_en) |=> (q == '0));

endmodule

// File: rtl/fpx_flag_reg.sv
module fpx_flag_reg
    import fpx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      op_done,
    input  exc_mask_t set_mask,
    input  logic      wr_en,
    input  exc_mask_t wr_val,
    output exc_mask_t q
);

    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (wr_en)   q <= wr_val;
        else if (op_done) q <= q | set_mask;
    end

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> ((q & $past(q)) == $past(q)));

endmodule

// File: rtl/fpx_field_reg.sv
module fpx_field_reg #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= '0;
        else if (wr_en) q <= wr_val;
    end

endmodule

// File: rtl/fpx_trap.sv
module fpx_trap
    import fpx_pkg::*;
(
    input  exc_vec_t  cause,
    input  exc_mask_t enable,
    output logic      trap
);

    exc_mask_t armed;

    always_comb begin
        armed = cause.mask & enable;
        trap  = cause.err | (|armed);
    end

endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_start,
    input  logic        op_done,
    input  logic [5:0]  op_exc,
    input  logic        cpu_wr_en,
    input  logic [31:0] cpu_wr_data,
    output logic [31:0] cpu_rd_data,
    output logic [1:0]  rnd_mode,
    output logic        trap_req
);

    csr_fields_t wr_f;
    csr_fields_t cur_f;
    exc_vec_t    exc_in;
    logic        unused_hi;

    assign wr_f      = csr_fields_t'(cpu_wr_data[USED_W-1:0]);
    assign unused_hi = ^cpu_wr_data[REG_W-1:USED_W];
    assign exc_in    = exc_vec_t'(op_exc);

    fpx_cause_reg u_cause (
        .clk      (clk),
        .rst      (rst),
        .op_start (op_start),
        .op_done  (op_done),
        .op_exc   (exc_in),
        .wr_en    (cpu_wr_en),
        .wr_val   (wr_f.cause),
        .q        (cur_f.cause)
    );

    fpx_flag_reg u_flags (
        .clk      (clk),
        .rst      (rst),
        .op_done  (op_done),
        .set_mask (exc_in.mask),
        .wr_en    (cpu_wr_en),
        .wr_val   (wr_f.flags),
        .q        (cur_f.flags)
    );

    fpx_field_reg #(.W(EXC_N)) u_enable (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cpu_wr_en),
        .wr_val (wr_f.enable),
        .q      (cur_f.enable)
    );

    fpx_field_reg #(.W(RM_W)) u_rm (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cpu_wr_en),
        .wr_val (wr_f.rm),
        .q      (cur_f.rm)
    );

    fpx_trap u_trap (
        .cause  (cur_f.cause),
        .enable (cur_f.enable),
        .trap   (trap_req)
    );

    assign cpu_rd_data = pack_csr(cur_f);
    assign rnd_mode    = rnd_decode(cur_f.rm);

    assert_err_trap_R6: assert property (@(posedge clk) disable iff (rst)
        (op_done && op_exc[5] && !cpu_wr_en) |=> trap_req);

    assert_enabled_trap_R7: assert property (@(posedge clk) disable iff (rst)
        (op_done && !cpu_wr_en && |(op_exc[4:0] & cpu_rd_data[11:7])) |=> trap_req);

    assert_cpu_wins_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_wr_en |=> (cpu_rd_data[17:0] == $past(cpu_wr_data[17:0])));

    assert_rnd_zero_R11: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr_en && cpu_wr_data[1:0] == 2'b01) |=> (rnd_mode == 2'b01));

endmodule

// File: tb/test_fpx_status_reg.sv
module test_fpx_status_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_start = 1'b0;
    logic        op_done = 1'b0;
    logic [5:0]  op_exc = '0;
    logic        cpu_wr_en = 1'b0;
    logic [31:0] cpu_wr_data = '0;
    logic [31:0] cpu_rd_data;
    logic [1:0]  rnd_mode;
    logic        trap_req;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fpx_status_reg i_fpx_status_reg (
        .clk         (clk),
        .rst         (rst),
        .op_start    (op_start),
        .op_done     (op_done),
        .op_exc      (op_exc),
        .cpu_wr_en   (cpu_wr_en),
        .cpu_wr_data (cpu_wr_data),
        .cpu_rd_data (cpu_rd_data),
        .rnd_mode    (rnd_mode),
        .trap_req    (trap_req)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Each stimulus starts on a falling edge, is captured on the next rising
    // edge and is read back on the following falling edge.
    task automatic step(logic s, logic d, logic [5:0] e, logic w, logic [31:0] wd);
        op_start = s; op_done = d; op_exc = e; cpu_wr_en = w; cpu_wr_data = wd;
        @(negedge clk);
        op_start = 0; op_done = 0; op_exc = '0; cpu_wr_en = 0; cpu_wr_data = '0;
    endtask

    task automatic t_reset();
        check("R1 rd", cpu_rd_data, 32'h0);
        check("R1 trap", {31'b0, trap_req}, 32'h0);
        check("R1 rnd", {30'b0, rnd_mode}, 32'h0);
    endtask

    task automatic t_write_all();
        step(0, 0, '0, 1, 32'hFFFF_FFFF);
        check("R9 R8 rd", cpu_rd_data, 32'h0003_FFFF);
        check("R6 trap", {31'b0, trap_req}, 32'h1);
        check("R11 rnd reserved 11", {30'b0, rnd_mode}, 32'h0);
        step(0, 0, '0, 1, 32'h0);
        check("R8 cleared", cpu_rd_data, 32'h0);
    endtask

    task automatic t_record();
        step(0, 1, 6'b010001, 0, '0);
        check("R3 rd", cpu_rd_data, (32'd1<<16)|(32'd1<<12)|(32'd1<<6)|(32'd1<<2));
        check("R7 no trap without enable", {31'b0, trap_req}, 32'h0);
    endtask

    task automatic t_start_clear();
        step(1, 0, '0, 0, '0);
        check("R2 R4 rd", cpu_rd_data, (32'd1<<6)|(32'd1<<2));
    endtask

    task automatic t_same_cycle();
        step(0, 1, 6'b000100, 0, '0);
        step(1, 1, 6'b001000, 0, '0);
        check("R5 rd", cpu_rd_data, (32'd1<<15)|(32'd1<<6)|(32'd1<<5)|(32'd1<<4)|(32'd1<<2));
        step(0, 1, 6'b000000, 0, '0);
        check("R4 sticky rd", cpu_rd_data, (32'd1<<15)|(32'd1<<6)|(32'd1<<5)|(32'd1<<4)|(32'd1<<2));
    endtask

    task automatic t_err();
        step(0, 0, '0, 1, 32'h0);
        step(0, 1, 6'b100000, 0, '0);
        check("R3 err rd", cpu_rd_data, 32'd1<<17);
        check("R6 err trap", {31'b0, trap_req}, 32'h1);
    endtask

    task automatic t_enabled();
        step(0, 0, '0, 1, 32'd1<<10);
        check("R7 idle trap", {31'b0, trap_req}, 32'h0);
        step(0, 1, 6'b001000, 0, '0);
        check("R7 rd", cpu_rd_data, (32'd1<<15)|(32'd1<<10)|(32'd1<<5));
        check("R7 trap", {31'b0, trap_req}, 32'h1);
    endtask

    task automatic t_cpu_wins();
        step(1, 1, 6'b111111, 1, 32'h0000_0001);
        check("R10 rd", cpu_rd_data, 32'h1);
        check("R10 trap", {31'b0, trap_req}, 32'h0);
    endtask

    task automatic t_rounding();
        step(0, 0, '0, 1, 32'h1);
        check("R11 rnd 01", {30'b0, rnd_mode}, 32'h1);
        step(0, 0, '0, 1, 32'h2);
        check("R11 rnd 10", {30'b0, rnd_mode}, 32'h0);
        check("R11 raw 10", cpu_rd_data, 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_write_all();
        t_record();
        t_start_clear();
        t_same_cycle();
        t_err();
        t_enabled();
        t_cpu_wins();
        t_rounding();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule